// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a slave on a two-wire serial bus with a clock line (SCL) and a shared open-drain data line (SDA). It holds the configuration for a video front end's sampling clock: a sampling phase step, an oscillator band select, a loop charge-pump current code and an output-port swap bit. Each field takes a fixed value at reset and is brought out as a port for the datapath to use. What these settings do in the analog domain is not part of this block.

A bus master opens a transfer with a start condition and then sends a 7-bit device address plus a direction bit. The top five address bits are fixed and the low two come from strap pins, so up to four of these blocks can share one bus. A write sends a register pointer and then data bytes, which go to consecutive registers. A read returns bytes from the current pointer until the master declines to acknowledge one. Both bus lines are re-timed onto a system clock that runs at least eight times faster than SCL.

Top module: `cfg_2w_slave`

## Requirements
- R1: After reset the outputs are phase_o=16, vco_band_o=2'b01, cp_code_o=3'b001 and port_swap_o=0, and sda_oe_o is 0.
- R2: The block acknowledges an address byte, by asserting sda_oe_o through the ninth SCL high time, only when its upper seven bits equal {5'b10011, addr_strap_i[1:0]}. On any other address it keeps SDA released for the rest of the transfer and changes no register.
- R3: In a write (direction bit 0), the byte after the address is loaded as the register pointer. Each later byte is written to the register the pointer names, then the pointer increments by one, wrapping from 8'hFF to 8'h00. Every byte is sent MSB first, and each byte of a write to a matched address is acknowledged.
- R4: In a read (direction bit 1), bytes are returned MSB first starting at the current pointer, and the pointer increments after each byte. Register 8'h0B reads {3'b0, phase}, and register 8'h0C reads {3'b0, cp_code, vco_band}.
- R5: When the master leaves SDA high in the acknowledge slot after a read byte, the block stops driving. It keeps SDA released through any further SCL pulses until the next start.
- R6: The port-swap bit is written at bit 4 of register 8'h0D and read back at bit 7 of that register. All other bits of 8'h0D read 0.
- R7: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start begins a new address phase without losing the pointer. A stop in the middle of a byte abandons that byte without a write.
- R8: Writes to any register other than 8'h0B, 8'h0C and 8'h0D, and to the unused bits of those registers, have no effect. Such registers read 8'h00.
- R9: sda_oe_o is the only SDA drive, and it is active-low open-drain only. It changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (resolved wire) |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_strap_i | input | 2 | Low two bits of the device address |
| phase_o | output | 5 | Sampling phase step, 32 steps per pixel |
| vco_band_o | output | 2 | Oscillator band select |
| cp_code_o | output | 3 | Charge-pump current code |
| port_swap_o | output | 1 | Swap which output port takes the first pixel |

## Verification
A wrong bit counter or a wrong FSM state shows up within one byte time. It appears as a missing or misplaced acknowledge, or as read data shifted by one bit, because the bench samples SDA at the middle of every SCL high time. A wrong pointer shows up on the next read, as bytes that come from the neighbouring register. A bad write path shows up on the field ports about three system clocks after the falling edge of the eighth SCL pulse. A drive enable that toggles while SCL is high is flagged in the same cycle by a monitor on the port.

// File: rtl/cfg_2w_pkg.sv
package cfg_2w_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned PHASE_W = 5;
  localparam int unsigned BAND_W  = 2;
  localparam int unsigned CP_W    = 3;

  localparam logic [4:0] DEV_PREFIX = 5'b10011;

  localparam logic [BYTE_W-1:0] REG_PHASE = 8'h0B;
  localparam logic [BYTE_W-1:0] REG_PLL   = 8'h0C;
  localparam logic [BYTE_W-1:0] REG_PORT  = 8'h0D;

  localparam int unsigned SWAP_WR_BIT = 4;
  localparam int unsigned SWAP_RD_BIT = 7;

  localparam logic [PHASE_W-1:0] PHASE_RST = 5'd16;
  localparam logic [BAND_W-1:0]  BAND_RST  = 2'b01;
  localparam logic [CP_W-1:0]    CP_RST    = 3'b001;

  typedef enum logic [2:0] {
    LK_IDLE, LK_ADDR, LK_PTR, LK_WDATA, LK_RDATA, LK_IGNORE
  } link_st_e;
endpackage

// File: rtl/cfg_2w_sync.sv
module cfg_2w_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] lvl;
  logic [LINES-1:0] lvl_d;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_d <= '1;
    else         lvl_d <= lvl;
  end

  assign scl_o      = lvl[0];
  assign sda_o      = lvl[1];
  assign scl_rise_o = lvl[0] & ~lvl_d[0];
  assign scl_fall_o = ~lvl[0] & lvl_d[0];
  // SDA edges with SCL held high are bus conditions
  assign start_o    = lvl[0] & lvl_d[0] & ~lvl[1] & lvl_d[1];
  assign stop_o     = lvl[0] & lvl_d[0] & lvl[1] & ~lvl_d[1];

  p_start_scl_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o || stop_o) |-> (scl_o && !scl_rise_o && !scl_fall_o));
endmodule

// File: rtl/cfg_2w_regfile.sv
module cfg_2w_regfile
  import cfg_2w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [BYTE_W-1:0] rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic [BAND_W-1:0]  band_o,
  output logic [CP_W-1:0]    cp_o,
  output logic               swap_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PHASE_RST;
      band_o  <= BAND_RST;
      cp_o    <= CP_RST;
      swap_o  <= 1'b0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        REG_PHASE: phase_o <= wr_data_i[PHASE_W-1:0];
        REG_PLL: begin
          band_o <= wr_data_i[BAND_W-1:0];
          cp_o   <= wr_data_i[BAND_W+CP_W-1:BAND_W];
        end
        REG_PORT:  swap_o <= wr_data_i[SWAP_WR_BIT];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (rd_addr_i)
      REG_PHASE: rd_data_o[PHASE_W-1:0] = phase_o;
      REG_PLL:   rd_data_o[BAND_W+CP_W-1:0] = {cp_o, band_o};
      REG_PORT:  rd_data_o[SWAP_RD_BIT] = swap_o; // read position differs from write
      default: ;
    endcase
  end

  p_hold_without_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable({phase_o, band_o, cp_o, swap_o}));
endmodule

// File: rtl/cfg_2w_link.sv
module cfg_2w_link
  import cfg_2w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              sda_oe_o
);
  localparam int unsigned CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  link_st_e          st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              in_ack_q;
  logic              rw_q;
  logic              mnack_q;
  logic [BYTE_W-1:0] sh_q;
  logic [BYTE_W-1:0] tx_q;
  logic [BYTE_W-1:0] ptr_q;
  logic              oe_q;
  logic              addr_hit;

  assign addr_hit = (sh_q[BYTE_W-1:1] == {DEV_PREFIX, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= LK_IDLE;
      cnt_q     <= '0;
      in_ack_q  <= 1'b0;
      rw_q      <= 1'b0;
      mnack_q   <= 1'b1;
      sh_q      <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      oe_q      <= 1'b0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        st_q <= LK_ADDR; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
      end else if (stop_i) begin
        st_q <= LK_IDLE; cnt_q <= '0; in_ack_q <= 1'b0; oe_q <= 1'b0;
      end else if (st_q == LK_IDLE || st_q == LK_IGNORE) begin
        // wait for next start
      end else if (scl_rise_i) begin
        if (in_ack_q) mnack_q <= sda_i;
        else if (cnt_q < LAST_BIT) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (scl_fall_i) begin
        if (in_ack_q) begin
          // end of acknowledge slot
          in_ack_q <= 1'b0;
          cnt_q    <= '0;
          unique case (st_q)
            LK_ADDR: begin
              if (rw_q) begin
                st_q <= LK_RDATA; tx_q <= rd_data_i; oe_q <= ~rd_data_i[BYTE_W-1];
              end else begin
                st_q <= LK_PTR; oe_q <= 1'b0;
              end
            end
            LK_PTR:   begin st_q <= LK_WDATA; oe_q <= 1'b0; end
            LK_WDATA: oe_q <= 1'b0;
            LK_RDATA: begin
              if (!mnack_q) begin
                tx_q <= rd_data_i; oe_q <= ~rd_data_i[BYTE_W-1];
              end else begin
                st_q <= LK_IGNORE; oe_q <= 1'b0;
              end
            end
            default: oe_q <= 1'b0;
          endcase
        end else if (cnt_q == LAST_BIT) begin
          // eighth bit done: enter acknowledge slot
          in_ack_q <= 1'b1;
          unique case (st_q)
            LK_ADDR: begin
              if (addr_hit) begin oe_q <= 1'b1; rw_q <= sh_q[0]; end
              else st_q <= LK_IGNORE;
            end
            LK_PTR: begin ptr_q <= sh_q; oe_q <= 1'b1; end
            LK_WDATA: begin
              wr_en_o   <= 1'b1;
              wr_addr_o <= ptr_q;
              wr_data_o <= sh_q;
              ptr_q     <= ptr_q + 1'b1;
              oe_q      <= 1'b1;
            end
            LK_RDATA: begin oe_q <= 1'b0; ptr_q <= ptr_q + 1'b1; end
            default: oe_q <= 1'b0;
          endcase
        end else if (st_q == LK_RDATA && cnt_q != '0) begin
          tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
          oe_q <= ~tx_q[BYTE_W-2];
        end
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign sda_oe_o = oe_q;

  p_oe_moves_scl_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(oe_q) |-> !scl_i);
  p_ignore_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_IGNORE || st_q == LK_IDLE) |-> !oe_q);
  p_write_steps_ptr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (ptr_q == wr_addr_o + 1'b1) && !scl_i);
  p_nack_ends_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == LK_RDATA && in_ack_q && scl_fall_i && mnack_q && !start_i && !stop_i)
      |=> (st_q == LK_IGNORE && !oe_q));
endmodule

// File: rtl/cfg_2w_slave.sv
module cfg_2w_slave
  import cfg_2w_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  input  logic [1:0]         addr_strap_i,
  output logic [PHASE_W-1:0] phase_o,
  output logic [BAND_W-1:0]  vco_band_o,
  output logic [CP_W-1:0]    cp_code_o,
  output logic               port_swap_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_addr, wr_data, ptr, rd_data;

  cfg_2w_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_ev), .stop_o(stop_ev)
  );

  cfg_2w_link u_link (
    .clk_i, .rst_ni, .scl_i(scl_s), .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_ev), .stop_i(stop_ev), .strap_i(addr_strap_i),
    .rd_data_i(rd_data), .wr_en_o(wr_en), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .ptr_o(ptr), .sda_oe_o
  );

  cfg_2w_regfile u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(ptr), .rd_data_o(rd_data),
    .phase_o, .band_o(vco_band_o), .cp_o(cp_code_o), .swap_o(port_swap_o)
  );
endmodule

// File: tb/cfg_2w_slave_tb_top.sv
module cfg_2w_slave_tb_top;
  localparam int Q = 8; // quarter SCL period in system clocks
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [6:0] MY_ADDR = {5'b10011, STRAP};

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [4:0] phase;
  logic [1:0] band;
  logic [2:0] cp;
  logic swap;

  always #4 clk = ~clk; // 125 MHz

  assign sda_line = m_sda & ~sda_oe;

  cfg_2w_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_strap_i(STRAP), .phase_o(phase), .vco_band_o(band), .cp_code_o(cp),
    .port_swap_o(swap)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  int r9_viol = 0;
  logic oe_prev = 1'b0;

  logic [4:0] e_phase = 5'd16;
  logic [1:0] e_band = 2'b01;
  logic [2:0] e_cp = 3'b001;
  logic       e_swap = 1'b0;
  logic [7:0] e_ptr = 8'h00;
  logic [7:0] wbuf [4];

  // R9 monitor: drive enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_ni && sda_oe !== oe_prev && scl) r9_viol++;
    oe_prev = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h0B:   return {3'b0, e_phase};
      8'h0C:   return {3'b0, e_cp, e_band};
      8'h0D:   return {e_swap, 7'b0};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h0B: e_phase = d[4:0];
      8'h0C: begin e_band = d[1:0]; e_cp = d[4:2]; end
      8'h0D: e_swap = d[4];
      default: ;
    endcase
  endtask

  task automatic chk_outs(input string req);
    chk(phase == e_phase, req, "phase_o", phase, e_phase);
    chk(band == e_band, req, "vco_band_o", band, e_band);
    chk(cp == e_cp, req, "cp_code_o", cp, e_cp);
    chk(swap == e_swap, req, "port_swap_o", swap, e_swap);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(2*Q);
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q); ack = sda_line;
    tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic mnack);
    b = '0;
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q); scl = 1'b1; tick(Q); b = {b[6:0], sda_line}; tick(Q); scl = 1'b0;
    end
    tick(Q);
    m_sda = mnack; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
    m_sda = 1'b1;
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n,
                        input string req);
    logic ack;
    bit hit = (a == MY_ADDR);
    bus_start();
    send_byte({a, 1'b0}, ack);
    chk(ack == !hit, "R2", "address ack level", ack, !hit);
    send_byte(p, ack);
    chk(ack == !hit, req, "pointer ack level", ack, !hit);
    if (hit) e_ptr = p;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      chk(ack == !hit, req, "data ack level", ack, !hit);
      if (hit) begin model_wr(e_ptr, wbuf[i]); e_ptr = e_ptr + 8'd1; end
    end
    bus_stop();
    tick(2);
    chk_outs(req);
  endtask

  task automatic rd_txn(input logic [7:0] p, input int n, input string req,
                        input bit set_ptr, input bit tail);
    logic ack;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte({MY_ADDR, 1'b0}, ack);
      send_byte(p, ack);
      e_ptr = p;
      bus_start(); // repeated start
    end
    send_byte({MY_ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R2", "read address ack", ack, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(b, (i == n - 1));
      chk(b == exp_rd(e_ptr), req, $sformatf("read byte @%0h", e_ptr), b, exp_rd(e_ptr));
      e_ptr = e_ptr + 8'd1;
    end
    if (tail) begin
      // R5: after master nack, further clocks must see a released line
      recv_byte(b, 1'b1);
      chk(b == 8'hFF, "R5", "line after nack", b, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    void'($urandom(32'h2C0F));
    tick(5);
    chk(sda_oe == 1'b0, "R1", "sda_oe_o in reset", sda_oe, 0);
    rst_ni = 1'b1;
    tick(5);
    chk_outs("R1");
    chk(sda_oe == 1'b0, "R1", "sda_oe_o after reset", sda_oe, 0);

    // defaults through the read path
    rd_txn(8'h0B, 3, "R4", 1, 0);

    // burst write of all fields
    wbuf[0] = 8'hE7; wbuf[1] = 8'hFE; wbuf[2] = 8'h10;
    wr_txn(MY_ADDR, 8'h0B, 3, "R3");
    rd_txn(8'h0B, 3, "R4", 1, 0);

    // R6: written at bit 4, seen at bit 7; other write bits ignored
    wbuf[0] = 8'hEF;
    wr_txn(MY_ADDR, 8'h0D, 1, "R6");
    rd_txn(8'h0D, 1, "R6", 1, 0);
    wbuf[0] = 8'h10;
    wr_txn(MY_ADDR, 8'h0D, 1, "R6");
    rd_txn(8'h0D, 1, "R6", 1, 0);

    // R2: other strap values and other prefixes do not respond
    wbuf[0] = 8'h03; wbuf[1] = 8'h1F;
    wr_txn({5'b10011, 2'b01}, 8'h0B, 2, "R2");
    wr_txn({5'b00011, STRAP}, 8'h0B, 2, "R2");

    // R8: unmapped registers and pointer wrap
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
    wr_txn(MY_ADDR, 8'h20, 2, "R8");
    rd_txn(8'h20, 2, "R8", 1, 0);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22;
    wr_txn(MY_ADDR, 8'hFF, 2, "R8");
    chk(e_ptr == 8'h01, "R3", "model pointer wrap", e_ptr, 1);
    rd_txn(8'h0A, 4, "R8", 1, 0);

    // R5: nack ends read, line stays released
    rd_txn(8'h0C, 2, "R5", 1, 1);

    // R4: read continues from current pointer (no pointer byte)
    rd_txn(8'h00, 2, "R4", 0, 0);

    // R7: stop in the middle of a data byte abandons it
    begin
      logic ack;
      bus_start();
      send_byte({MY_ADDR, 1'b0}, ack);
      send_byte(8'h0B, ack);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
      bus_stop();
      tick(4);
      chk_outs("R7");
      e_ptr = 8'h0B;
    end
    wbuf[0] = 8'h05;
    wr_txn(MY_ADDR, 8'h0B, 1, "R7");

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [7:0] p = 8'h0A + 8'($urandom % 5);
      int n = 1 + int'($urandom % 3);
      if ($urandom % 2) begin
        for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom);
        wr_txn(MY_ADDR, p, n, "R3");
      end else begin
        rd_txn(p, n, "R4", 1, 0);
      end
    end

    chk(r9_viol == 0, "R9", "oe changes while SCL high", r9_viol, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule